// File: doc/BRIEF.md
# Per-Channel Calibration Interpolator with Polarization Converter

This block calibrates a stream of channelized dual-polarization samples. For every antenna it keeps a coarse table of four complex correction terms at a small number of frequency points. The four terms are two complex gains, one per polarization, and two complex cross-coupling (leakage) terms. As each sample pair arrives, the block expands the coarse table into the value for that channel by straight-line interpolation. It then applies the resulting 2x2 correction to the X/Y pair.

Each beat carries a mode bit. When the bit is clear, the corrected linear pair leaves the block. When it is set, the pair is first rotated to right- and left-hand circular form and scaled by the inverse square root of two.

Table updates go into a shadow copy while the active copy keeps serving traffic. A commit pulse arms a swap, and the swap takes effect at the start of the next spectrum. Samples enter and leave on valid/ready streams. A beat moves when valid and ready are both high at a rising edge. A stalled output holds its data. The input ready drops only when both internal stages are full and the consumer is not ready. Beats are never dropped, duplicated or reordered.

Top module: `cal_interp_top`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Channels per segment: S = N_CH/N_PTS. For channel c, let k = c/S and w = c mod S. Each real and imaginary coefficient part is then a_k + floor((a_(k+1) − a_k)·w/S), where a_k is table point k. At w = 0 the value equals table point k exactly.
- R3: In the last segment (k = N_PTS−1) every channel uses table point N_PTS−1 unchanged.
- R4: Coefficients are signed with 14 fraction bits. wr_sel selects the term: 0 = X gain, 1 = Y gain, 2 = X leakage, 3 = Y leakage. The linear outputs are X′ = gX·X + lX·Y and Y′ = lY·X + gY·Y. Each part is rounded half-up after dropping the 14 fraction bits. X′ is placed on the P output and Y′ on the Q output.
- R5: With in_circ set, P = (X′ + jY′)·K and Q = (X′ − jY′)·K, where K = 23170/32768. Both are computed from the unrounded X′ and Y′ and rounded half-up only once.
- R6: Every output part saturates to the signed range of DW bits.
- R7: A table write goes to the inactive copy and does not change any output until a commit has been followed by a swap.
- R8: After a commit, the swap happens on the first accepted beat whose channel is 0, and that beat already uses the new copy. Beats accepted before it use the old copy.
- R9: While out_valid is high and out_ready is low, all outputs hold. Every accepted beat leaves exactly once, in order.
- R10: The mode bit is taken from each beat at acceptance, so consecutive beats may alternate modes.
- R11: A beat accepted at one edge, followed by out_ready high in the next cycle, shows out_valid at the second edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write strobe |
| wr_ant | input | ANTW | Antenna of the written entry |
| wr_pt | input | PTW | Coarse point of the written entry |
| wr_sel | input | 2 | Term select (0 X gain, 1 Y gain, 2 X leakage, 3 Y leakage) |
| wr_re | input | CW | Real part of the written term |
| wr_im | input | CW | Imaginary part of the written term |
| commit | input | 1 | Arms a copy swap at the next spectrum start |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_ant | input | ANTW | Antenna of the beat |
| in_chan | input | CHW | Channel index of the beat |
| in_circ | input | 1 | 1 = circular output, 0 = linear output |
| in_x_re | input | DW | X sample, real part |
| in_x_im | input | DW | X sample, imaginary part |
| in_y_re | input | DW | Y sample, real part |
| in_y_im | input | DW | Y sample, imaginary part |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready |
| out_p_re | output | DW | X′ or right-hand part, real |
| out_p_im | output | DW | X′ or right-hand part, imaginary |
| out_q_re | output | DW | Y′ or left-hand part, real |
| out_q_im | output | DW | Y′ or left-hand part, imaginary |

## Verification
The bench builds the block with 3 antennas, 8 coarse points and 64 channels, so each segment spans 8 channels. With spectra this short, every interpolation weight, the held final segment and many spectrum starts all occur within a few hundred beats. That makes it practical to exercise repeated copy swaps, writes that must stay invisible before a commit, and commits that arrive in mid-spectrum. Random back-pressure combined with alternating modes drives the two-stage pipeline through every fill and stall pattern.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    SEL_GX = 2'd0,
    SEL_GY = 2'd1,
    SEL_DX = 2'd2,
    SEL_DY = 2'd3
  } cal_sel_e;

  localparam int NPAR  = 4;      // complex terms per coarse point
  localparam int KFRAC = 15;     // fraction bits of the circular scale
  localparam int KINV  = 23170;  // round(2^15 / sqrt(2))
endpackage

// File: rtl/cal_table.sv
module cal_table #(
  parameter int N_ANT = 34,
  parameter int N_PTS = 64,
  parameter int CW    = 16,
  localparam int ANTW = (N_ANT > 1) ? $clog2(N_ANT) : 1,
  localparam int PTW  = $clog2(N_PTS),
  localparam int EW   = cal_pkg::NPAR * 2 * CW
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [ANTW-1:0] wr_ant,
  input  logic [PTW-1:0]  wr_pt,
  input  logic [1:0]      wr_sel,
  input  logic [2*CW-1:0] wr_data,
  input  logic            rd_bank,
  input  logic [ANTW-1:0] rd_ant,
  input  logic [PTW-1:0]  rd_pt,
  output logic [EW-1:0]   rd_lo,
  output logic [EW-1:0]   rd_hi
);
  localparam int PER_BANK = N_ANT * N_PTS;
  localparam int DEPTH    = 2 * PER_BANK;
  localparam int AW       = $clog2(DEPTH);

  logic [EW-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] addr_of(input logic bank, input logic [ANTW-1:0] ant,
                                            input logic [PTW-1:0] pt);
    return AW'(bank) * AW'(PER_BANK) + AW'(ant) * AW'(N_PTS) + AW'(pt);
  endfunction

  logic [AW-1:0] wa, ra_lo, ra_hi;
  logic [PTW-1:0] pt_next;

  assign wa      = addr_of(wr_bank, wr_ant, wr_pt);
  // final segment holds the last point instead of reading beyond the table
  assign pt_next = (rd_pt == PTW'(N_PTS - 1)) ? rd_pt : rd_pt + PTW'(1);
  assign ra_lo   = addr_of(rd_bank, rd_ant, rd_pt);
  assign ra_hi   = addr_of(rd_bank, rd_ant, pt_next);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa][wr_sel*2*CW +: 2*CW] <= wr_data;
  end

  assign rd_lo = mem[ra_lo];
  assign rd_hi = mem[ra_hi];
endmodule

// File: rtl/cal_lerp.sv
module cal_lerp #(
  parameter int CW = 16,
  parameter int WB = 6
) (
  input  logic signed [CW-1:0] lo,
  input  logic signed [CW-1:0] hi,
  input  logic        [WB-1:0] w,
  output logic signed [CW-1:0] v
);
  localparam int PW = CW + WB + 2;

  logic signed [CW:0]   diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] step;

  assign diff = {hi[CW-1], hi} - {lo[CW-1], lo};
  assign prod = PW'(diff) * PW'($signed({1'b0, w}));
  assign step = prod >>> WB;  // floor division by the segment length
  assign v    = lo + $signed(step[CW-1:0]);
endmodule

// File: rtl/cal_apply.sv
module cal_apply #(
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int EW = cal_pkg::NPAR * 2 * CW
) (
  input  logic [EW-1:0]        coef,
  input  logic                 circ,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic signed [DW-1:0] y_re,
  input  logic signed [DW-1:0] y_im,
  output logic signed [DW-1:0] p_re,
  output logic signed [DW-1:0] p_im,
  output logic signed [DW-1:0] q_re,
  output logic signed [DW-1:0] q_im
);
  import cal_pkg::*;

  localparam int SW    = DW + CW + 2;
  localparam int CFRAC = CW - 2;
  localparam longint MAXV = (64'sd1 <<< (DW - 1)) - 64'sd1;
  localparam longint MINV = -(64'sd1 <<< (DW - 1));

  function automatic logic signed [SW-1:0] mul(input logic signed [DW-1:0] a,
                                               input logic signed [CW-1:0] b);
    return SW'(a) * SW'(b);
  endfunction

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [63:0] v, input int sh);
    logic signed [63:0] t;
    t = (v + (64'sd1 <<< (sh - 1))) >>> sh;
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DW-1:0];
  endfunction

  logic signed [CW-1:0] c_re [NPAR];
  logic signed [CW-1:0] c_im [NPAR];

  for (genvar s = 0; s < NPAR; s++) begin : g_unpack
    assign c_re[s] = coef[s*2*CW + CW +: CW];
    assign c_im[s] = coef[s*2*CW +: CW];
  end

  localparam int GX = int'(SEL_GX);
  localparam int GY = int'(SEL_GY);
  localparam int LX = int'(SEL_DX);
  localparam int LY = int'(SEL_DY);

  logic signed [SW-1:0] sx_re, sx_im, sy_re, sy_im;
  logic signed [63:0]   r_re, r_im, l_re, l_im;

  assign sx_re = mul(x_re, c_re[GX]) - mul(x_im, c_im[GX]) + mul(y_re, c_re[LX]) - mul(y_im, c_im[LX]);
  assign sx_im = mul(x_im, c_re[GX]) + mul(x_re, c_im[GX]) + mul(y_im, c_re[LX]) + mul(y_re, c_im[LX]);
  assign sy_re = mul(x_re, c_re[LY]) - mul(x_im, c_im[LY]) + mul(y_re, c_re[GY]) - mul(y_im, c_im[GY]);
  assign sy_im = mul(x_im, c_re[LY]) + mul(x_re, c_im[LY]) + mul(y_im, c_re[GY]) + mul(y_re, c_im[GY]);

  assign r_re = (64'(sx_re) - 64'(sy_im)) * 64'(KINV);
  assign r_im = (64'(sx_im) + 64'(sy_re)) * 64'(KINV);
  assign l_re = (64'(sx_re) + 64'(sy_im)) * 64'(KINV);
  assign l_im = (64'(sx_im) - 64'(sy_re)) * 64'(KINV);

  always_comb begin
    if (circ) begin
      p_re = rnd_sat(r_re, CFRAC + KFRAC);
      p_im = rnd_sat(r_im, CFRAC + KFRAC);
      q_re = rnd_sat(l_re, CFRAC + KFRAC);
      q_im = rnd_sat(l_im, CFRAC + KFRAC);
    end else begin
      p_re = rnd_sat(64'(sx_re), CFRAC);
      p_im = rnd_sat(64'(sx_im), CFRAC);
      q_re = rnd_sat(64'(sy_re), CFRAC);
      q_im = rnd_sat(64'(sy_im), CFRAC);
    end
  end
endmodule

// File: rtl/cal_interp_top.sv
module cal_interp_top #(
  parameter int N_ANT = 34,
  parameter int N_PTS = 64,
  parameter int N_CH  = 4096,
  parameter int DW    = 16,
  parameter int CW    = 16,
  localparam int ANTW = (N_ANT > 1) ? $clog2(N_ANT) : 1,
  localparam int PTW  = $clog2(N_PTS),
  localparam int CHW  = $clog2(N_CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ANTW-1:0]      wr_ant,
  input  logic [PTW-1:0]       wr_pt,
  input  logic [1:0]           wr_sel,
  input  logic signed [CW-1:0] wr_re,
  input  logic signed [CW-1:0] wr_im,
  input  logic                 commit,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ANTW-1:0]      in_ant,
  input  logic [CHW-1:0]       in_chan,
  input  logic                 in_circ,
  input  logic signed [DW-1:0] in_x_re,
  input  logic signed [DW-1:0] in_x_im,
  input  logic signed [DW-1:0] in_y_re,
  input  logic signed [DW-1:0] in_y_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_p_re,
  output logic signed [DW-1:0] out_p_im,
  output logic signed [DW-1:0] out_q_re,
  output logic signed [DW-1:0] out_q_im
);
  import cal_pkg::*;

  localparam int SEG = N_CH / N_PTS;
  localparam int WB  = $clog2(SEG);
  localparam int EW  = NPAR * 2 * CW;
  localparam int NC  = NPAR * 2;

  // ---------------- copy selection ----------------
  logic act_bank, pending, at_sof, rd_bank, accept, swap;

  assign accept  = in_valid && in_ready;
  assign at_sof  = (in_chan == '0);
  assign rd_bank = (pending && at_sof) ? ~act_bank : act_bank;
  assign swap    = accept && pending && at_sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_bank <= 1'b0;
      pending  <= 1'b0;
    end else if (swap) begin
      act_bank <= ~act_bank;
      pending  <= commit;
    end else if (commit) begin
      pending  <= 1'b1;
    end
  end

  // ---------------- coarse table and interpolation ----------------
  logic [EW-1:0] rd_lo, rd_hi, coef_w;

  cal_table #(.N_ANT(N_ANT), .N_PTS(N_PTS), .CW(CW)) u_table (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_bank (~act_bank),
    .wr_ant  (wr_ant),
    .wr_pt   (wr_pt),
    .wr_sel  (wr_sel),
    .wr_data ({wr_re, wr_im}),
    .rd_bank (rd_bank),
    .rd_ant  (in_ant),
    .rd_pt   (in_chan[CHW-1:WB]),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi)
  );

  for (genvar i = 0; i < NC; i++) begin : g_lerp
    cal_lerp #(.CW(CW), .WB(WB)) u_lerp (
      .lo (rd_lo[i*CW +: CW]),
      .hi (rd_hi[i*CW +: CW]),
      .w  (in_chan[WB-1:0]),
      .v  (coef_w[i*CW +: CW])
    );
  end

  // ---------------- stage A: coefficients and samples ----------------
  logic                 va, vb, a_ready, b_ready, a_circ;
  logic [EW-1:0]        a_coef;
  logic signed [DW-1:0] a_xr, a_xi, a_yr, a_yi;

  assign b_ready  = !vb || out_ready;
  assign a_ready  = !va || b_ready;
  assign in_ready = a_ready;

  always_ff @(posedge clk) begin
    if (rst) va <= 1'b0;
    else if (a_ready) va <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      a_coef <= coef_w;
      a_circ <= in_circ;
      a_xr   <= in_x_re;
      a_xi   <= in_x_im;
      a_yr   <= in_y_re;
      a_yi   <= in_y_im;
    end
  end

  // ---------------- stage B: correction and output ----------------
  logic signed [DW-1:0] n_pr, n_pi, n_qr, n_qi;

  cal_apply #(.DW(DW), .CW(CW)) u_apply (
    .coef (a_coef),
    .circ (a_circ),
    .x_re (a_xr),
    .x_im (a_xi),
    .y_re (a_yr),
    .y_im (a_yi),
    .p_re (n_pr),
    .p_im (n_pi),
    .q_re (n_qr),
    .q_im (n_qi)
  );

  always_ff @(posedge clk) begin
    if (rst) vb <= 1'b0;
    else if (b_ready) vb <= va;
  end

  always_ff @(posedge clk) begin
    if (va && b_ready) begin
      out_p_re <= n_pr;
      out_p_im <= n_pi;
      out_q_re <= n_qr;
      out_q_im <= n_qi;
    end
  end

  assign out_valid = vb;
endmodule

// File: rtl/cal_interp_chk.sv
module cal_interp_chk #(
  parameter int CHW = 12,
  parameter int DW  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 commit,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [CHW-1:0]       in_chan,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_p_re,
  input logic signed [DW-1:0] out_p_im,
  input logic signed [DW-1:0] out_q_re,
  input logic signed [DW-1:0] out_q_im,
  input logic                 act_bank,
  input logic                 pending
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));

  assert_commit_arms_R7: assert property (@(posedge clk) disable iff (rst)
    commit |=> pending);

  assert_swap_at_sof_R8: assert property (@(posedge clk) disable iff (rst)
    (act_bank != $past(act_bank)) |-> $past(pending && in_valid && in_ready && in_chan == '0));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p_re) && $stable(out_p_im)
                                   && $stable(out_q_re) && $stable(out_q_im)));

  assert_two_cycle_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);
endmodule

bind cal_interp_top cal_interp_chk #(.CHW(CHW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .commit    (commit),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_chan   (in_chan),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_p_re  (out_p_re),
  .out_p_im  (out_p_im),
  .out_q_re  (out_q_re),
  .out_q_im  (out_q_im),
  .act_bank  (act_bank),
  .pending   (pending)
);

// File: tb/cal_interp_top_bench.sv
module cal_interp_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 3, NP = 8, NCH = 64, DW = 16, CW = 16;
  localparam int SEG = NCH / NP, WB = 3, ANTW = 2, PTW = 3, CHW = 6;
  localparam int CF = 14, KF = 15, KI = 23170;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, commit = 0, in_valid = 0, in_circ = 0, out_ready = 0;
  logic [ANTW-1:0] wr_ant = '0, in_ant = '0;
  logic [PTW-1:0] wr_pt = '0;
  logic [1:0] wr_sel = '0;
  logic signed [CW-1:0] wr_re = '0, wr_im = '0;
  logic [CHW-1:0] in_chan = '0;
  logic signed [DW-1:0] in_x_re = '0, in_x_im = '0, in_y_re = '0, in_y_im = '0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] out_p_re, out_p_im, out_q_re, out_q_im;

  cal_interp_top #(.N_ANT(NA), .N_PTS(NP), .N_CH(NCH), .DW(DW), .CW(CW)) u_cal_interp_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ant(wr_ant), .wr_pt(wr_pt), .wr_sel(wr_sel),
    .wr_re(wr_re), .wr_im(wr_im), .commit(commit), .in_valid(in_valid), .in_ready(in_ready),
    .in_ant(in_ant), .in_chan(in_chan), .in_circ(in_circ), .in_x_re(in_x_re), .in_x_im(in_x_im),
    .in_y_re(in_y_re), .in_y_im(in_y_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_p_re(out_p_re), .out_p_im(out_p_im), .out_q_re(out_q_re), .out_q_im(out_q_im));

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { int pr; int pi; int qr; int qi; int cyc; string req; } exp_t;

  int tab [2][NA][NP][4][2];
  bit mbank = 0, mpend = 0;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_lat = 0, rand_rdy = 0, last_acc = 0, prev_stall = 0;
  string cur_req = "R2";
  int sv_pr, sv_pi, sv_qr, sv_qi;

  // staged drive values, applied at the falling edge
  logic d_wr_en = 0, d_commit = 0, d_valid = 0, d_circ = 0, d_ordy = 1;
  int d_wa = 0, d_wp = 0, d_ws = 0, d_wre = 0, d_wim = 0;
  int d_ant = 0, d_ch = 0, d_xr = 0, d_xi = 0, d_yr = 0, d_yi = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint rs(longint v, int sh);
    longint t = (v + (64'sd1 <<< (sh - 1))) >>> sh;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic longint cf(bit bk, int ant, int ch, int s, int c);
    int k = ch / SEG, w = ch % SEG;
    int a = tab[bk][ant][k][s][c];
    int b = (k == NP - 1) ? a : tab[bk][ant][k + 1][s][c];
    return longint'(a + (((b - a) * w) >>> WB));
  endfunction

  function automatic exp_t model(bit bk, int ant, int ch, bit circ, longint xr, longint xi,
                                 longint yr, longint yi);
    exp_t e;
    longint gxr = cf(bk, ant, ch, 0, 0), gxi = cf(bk, ant, ch, 0, 1);
    longint gyr = cf(bk, ant, ch, 1, 0), gyi = cf(bk, ant, ch, 1, 1);
    longint lxr = cf(bk, ant, ch, 2, 0), lxi = cf(bk, ant, ch, 2, 1);
    longint lyr = cf(bk, ant, ch, 3, 0), lyi = cf(bk, ant, ch, 3, 1);
    longint sxr = gxr * xr - gxi * xi + lxr * yr - lxi * yi;
    longint sxi = gxr * xi + gxi * xr + lxr * yi + lxi * yr;
    longint syr = lyr * xr - lyi * xi + gyr * yr - gyi * yi;
    longint syi = lyr * xi + lyi * xr + gyr * yi + gyi * yr;
    if (circ) begin
      e.pr = int'(rs((sxr - syi) * KI, CF + KF));
      e.pi = int'(rs((sxi + syr) * KI, CF + KF));
      e.qr = int'(rs((sxr + syi) * KI, CF + KF));
      e.qi = int'(rs((sxi - syr) * KI, CF + KF));
    end else begin
      e.pr = int'(rs(sxr, CF)); e.pi = int'(rs(sxi, CF));
      e.qr = int'(rs(syr, CF)); e.qi = int'(rs(syi, CF));
    end
    return e;
  endfunction

  task automatic tick();
    @(negedge clk);
    if (rand_rdy) d_ordy = 1'($urandom_range(0, 1));
    wr_en = d_wr_en; wr_ant = ANTW'(d_wa); wr_pt = PTW'(d_wp); wr_sel = 2'(d_ws);
    wr_re = CW'(d_wre); wr_im = CW'(d_wim); commit = d_commit;
    in_valid = d_valid; in_ant = ANTW'(d_ant); in_chan = CHW'(d_ch); in_circ = d_circ;
    in_x_re = DW'(d_xr); in_x_im = DW'(d_xi); in_y_re = DW'(d_yr); in_y_im = DW'(d_yi);
    out_ready = d_ordy;
    #1;
    cyc++;
    last_acc = 0;
    if (rst) return;
    if (prev_stall)
      check(out_valid && out_p_re == sv_pr && out_p_im == sv_pi && out_q_re == sv_qr
            && out_q_im == sv_qi, "R9", "stalled output held", out_p_re, sv_pr);
    if (out_valid && out_ready) begin
      if (q.size() == 0) check(0, "R9", "unexpected output beat", 1, 0);
      else begin
        exp_t e = q.pop_front();
        check(out_p_re == e.pr, e.req, "p_re", out_p_re, e.pr);
        check(out_p_im == e.pi, e.req, "p_im", out_p_im, e.pi);
        check(out_q_re == e.qr, e.req, "q_re", out_q_re, e.qr);
        check(out_q_im == e.qi, e.req, "q_im", out_q_im, e.qi);
        if (chk_lat) check(cyc - e.cyc == 2, "R11", "latency", cyc - e.cyc, 2);
      end
    end
    if (in_valid && in_ready) begin
      bit sof = (in_chan == 0);
      bit eb = (mpend && sof) ? !mbank : mbank;
      exp_t e = model(eb, int'(in_ant), int'(in_chan), in_circ, in_x_re, in_x_im, in_y_re, in_y_im);
      e.cyc = cyc;
      e.req = (cur_req == "R2" && int'(in_chan) >= NCH - SEG) ? "R3" : cur_req;
      q.push_back(e);
      last_acc = 1;
      if (mpend && sof) begin mbank = !mbank; mpend = commit; end
      else if (commit) mpend = 1;
    end else if (commit) mpend = 1;
    if (wr_en) begin
      tab[!mbank][wr_ant][wr_pt][wr_sel][0] = int'(wr_re);
      tab[!mbank][wr_ant][wr_pt][wr_sel][1] = int'(wr_im);
    end
    prev_stall = out_valid && !out_ready;
    sv_pr = out_p_re; sv_pi = out_p_im; sv_qr = out_q_re; sv_qi = out_q_im;
  endtask

  task automatic fill(bit extreme);
    d_wr_en = 1;
    for (int a = 0; a < NA; a++)
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < 4; s++) begin
          d_wa = a; d_wp = p; d_ws = s;
          d_wre = int'($urandom_range(0, 16383)) - 8192;
          d_wim = int'($urandom_range(0, 16383)) - 8192;
          if (extreme && a == 0 && p == 0) begin
            d_wre = (s == 0 || s == 2) ? 32767 : -32768;
            d_wim = 0;
          end
          tick();
        end
    d_wr_en = 0;
  endtask

  task automatic do_commit();
    d_commit = 1; tick(); d_commit = 0;
  endtask

  task automatic send(int ant, int ch, bit circ);
    d_valid = 1; d_ant = ant; d_ch = ch; d_circ = circ;
    d_xr = int'($urandom_range(0, 65535)) - 32768;
    d_xi = int'($urandom_range(0, 65535)) - 32768;
    d_yr = int'($urandom_range(0, 65535)) - 32768;
    d_yi = int'($urandom_range(0, 65535)) - 32768;
    do tick(); while (!last_acc);
    d_valid = 0;
  endtask

  task automatic drain();
    d_valid = 0; rand_rdy = 0; d_ordy = 1;
    for (int i = 0; i < 20; i++) if (q.size() != 0 || out_valid) tick();
    check(q.size() == 0 && !out_valid, "R9", "all beats delivered", q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) tick();
    rst = 0;
    tick();
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready, "R1", "in_ready after reset", in_ready, 1);

    fill(0); do_commit();
    // R2/R3/R11: full spectrum, unstalled, linear mode
    cur_req = "R2"; chk_lat = 1;
    for (int c = 0; c < NCH; c++) send(1, c, 0);
    drain(); chk_lat = 0;
    // R4: other antennas, linear
    cur_req = "R4";
    for (int c = 0; c < NCH; c += 3) send(2, c, 0);
    drain();
    // R5: circular conversion
    cur_req = "R5";
    for (int c = 0; c < NCH; c++) send(0, c, 1);
    drain();
    // R10: mode alternates beat by beat
    cur_req = "R10";
    for (int c = 0; c < 24; c++) send(1, c, 1'(c % 2));
    drain();
    // R7: shadow writes without commit stay invisible
    fill(0);
    cur_req = "R7";
    for (int c = 0; c < NCH; c += 2) send(1, c, 0);
    drain();
    // R8: commit mid-spectrum, swap at channel 0
    do_commit();
    cur_req = "R8";
    for (int c = 10; c < 20; c++) send(2, c, 0);
    for (int c = 0; c < 16; c++) send(2, c, 1'(c % 2));
    drain();
    // R6: saturation with extreme coefficients and samples
    fill(1); do_commit();
    cur_req = "R6";
    d_valid = 1; d_ant = 0; d_ch = 0; d_circ = 0;
    d_xr = 32767; d_xi = 0; d_yr = 32767; d_yi = 0;
    do tick(); while (!last_acc);
    d_ch = 1; d_circ = 1; d_xr = -32768; d_yr = -32768;
    do tick(); while (!last_acc);
    d_ch = 0; d_circ = 0;
    do tick(); while (!last_acc);
    drain();
    // R9: random back-pressure and gaps, with commits in flight
    cur_req = "R9"; rand_rdy = 1;
    for (int i = 0; i < 300; i++) begin
      if (i == 100) begin fill(0); do_commit(); end
      if ($urandom_range(0, 3) == 0) begin d_valid = 0; tick(); end
      send(int'($urandom_range(0, NA - 1)), i % NCH, 1'($urandom_range(0, 1)));
    end
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule